// File: doc/BRIEF.md
# Reconfigurable Region Isolation Controller

This block guards the boundary between a fixed part of a chip and a region whose logic can be swapped at run time. Software talks to it through a small register interface on a simple control bus. Through that interface it can hold the swappable region in reset and fence off everything the region drives toward the fixed side. While the fence is up, the region's 32-bit data word and its two flag outputs are replaced by a fixed idle value. Glitches that occur while new logic is being loaded therefore never reach the fixed side.

Out of power-on reset the region is both in reset and fenced. The fixed system can therefore run with the region empty. To bring up a freshly loaded module, software releases the reset first and then drops the fence. The block enforces that order. Reset stays asserted for a minimum number of cycles, and a request to drop the fence waits until reset has gone away. To tear a module down, software raises the fence and then the reset, before new logic is loaded. A status word reports the applied state. An optional interrupt pulses whenever the region becomes active or stops being active.

Top module: `region_fence`

## Requirements
- R1: After synchronous reset, `rgn_rst_o` is 1, the fence is up, `st_data_o` equals `IDLE_DATA` (default 0), `st_valid_o` and `st_req_o` are 0, and `irq_o` is 0. The control word reads 3 and the interrupt-enable word reads 0.
- R2: The register map, at `cb_addr` values, is as follows. 0 is the control word: bit 0 requests the fence and bit 1 requests region reset, both read/write. 1 is the status word, read-only, with bit 0 fence applied, bit 1 reset applied, bit 2 module active, and bit 3 fence-drop pending (fence requested off but still applied). 2 is the interrupt enable in bit 0. `cb_rdata` follows `cb_addr` combinationally. Address 3 reads 0, and writes to addresses 1 and 3 change nothing.
- R3: A write to the control word with bit 1 set asserts `rgn_rst_o` from the next clock edge. Reset then stays asserted for at least `RST_HOLD` (default 16) cycles counted from the last such write, even if bit 1 is cleared sooner. Once the hold has run out and bit 1 is 0, reset is released.
- R4: The fence is applied whenever region reset is applied, on the same edge. Setting control bit 0 applies it on the next edge. Clearing bit 0 while reset is not applied removes it on the next edge.
- R5: A fence-drop request made while region reset is applied is deferred. The fence comes down one cycle after `rgn_rst_o` falls, and status bit 3 is 1 during the wait.
- R6: The outputs toward the fixed side are registered. When the fence was not applied in the previous cycle, they carry the region's inputs from that cycle. In the cycle after the fence is applied, they carry the idle value.
- R7: The module is active when neither the fence nor reset is applied. When interrupts are enabled, `irq_o` is a one-cycle pulse in the cycle after the active flag changes, in either direction.
- R8: With interrupt enable at 0, `irq_o` stays 0 on any change of the active flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cb_sel | input | 1 | Control bus select |
| cb_wr | input | 1 | Control bus write strobe (with cb_sel) |
| cb_addr | input | 2 | Register address |
| cb_wdata | input | 32 | Write data |
| cb_rdata | output | 32 | Read data for cb_addr |
| rgn_data_i | input | 32 | Data word driven by the swappable region |
| rgn_valid_i | input | 1 | Valid flag driven by the region |
| rgn_req_i | input | 1 | Request flag driven by the region |
| st_data_o | output | 32 | Data word toward the fixed side, clamped when fenced |
| st_valid_o | output | 1 | Valid flag toward the fixed side, 0 when fenced |
| st_req_o | output | 1 | Request flag toward the fixed side, 0 when fenced |
| rgn_rst_o | output | 1 | Reset to the swappable region |
| irq_o | output | 1 | Interrupt pulse on active-state change |

## Verification
The checker checks several rules on every cycle. Reset never drops before its minimum hold has elapsed. The fence is up whenever the region is in reset, and it only comes down after reset has been released. The clamped outputs are idle in the cycle after the fence is applied. Every interrupt pulse follows a real change of the active flag while interrupts are enabled. Other behaviour can only be shown by the bench's scenarios. These are the register map and the effect of writes to read-only space, the exact edge on which the deferred fence drop happens, the one-cycle delay of the pass-through data, and the restart of the hold by a repeated reset write.

// File: rtl/region_fence_pkg.sv
package region_fence_pkg;

    localparam int DATA_W = 32;
    localparam int CB_W   = 32;
    localparam int ADDR_W = 2;
    localparam int BUS_W  = DATA_W + 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_STAT  = 2'd1,
        ADDR_IRQEN = 2'd2,
        ADDR_NONE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic rst;
        logic iso;
    } ctrl_t;

    typedef struct packed {
        logic pending;
        logic active;
        logic rst;
        logic iso;
    } status_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              req;
    } rgn_bus_t;

    function automatic rgn_bus_t idle_bus(input logic [DATA_W-1:0] idle_word);
        rgn_bus_t b;
        b.data  = idle_word;
        b.valid = 1'b0;
        b.req   = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/region_fence_regs.sv
module region_fence_regs
    import region_fence_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cb_sel,
    input  logic              cb_wr,
    input  logic [ADDR_W-1:0] cb_addr,
    input  logic [CB_W-1:0]   cb_wdata,
    input  status_t           status,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_nxt,
    output logic              rst_load,
    output logic              irq_en,
    output logic [CB_W-1:0]   cb_rdata
);

    logic wr_ctrl;
    logic wr_irqen;

    assign wr_ctrl  = cb_sel && cb_wr && (reg_addr_e'(cb_addr) == ADDR_CTRL);
    assign wr_irqen = cb_sel && cb_wr && (reg_addr_e'(cb_addr) == ADDR_IRQEN);

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr_ctrl) begin
            ctrl_nxt.iso = cb_wdata[0];
            ctrl_nxt.rst = cb_wdata[1];
        end
    end

    assign rst_load = wr_ctrl && cb_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{rst: 1'b1, iso: 1'b1};
            irq_en <= 1'b0;
        end else begin
            ctrl_q <= ctrl_nxt;
            if (wr_irqen) begin
                irq_en <= cb_wdata[0];
            end
        end
    end

    always_comb begin
        cb_rdata = '0;
        unique case (reg_addr_e'(cb_addr))
            ADDR_CTRL:  cb_rdata[1:0] = ctrl_q;
            ADDR_STAT:  cb_rdata[3:0] = status;
            ADDR_IRQEN: cb_rdata[0]   = irq_en;
            default:    cb_rdata      = '0;
        endcase
    end

endmodule

// File: rtl/region_fence_seq.sv
module region_fence_seq
    import region_fence_pkg::*;
#(
    parameter int RST_HOLD = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl_nxt,
    input  logic  rst_load,
    input  logic  irq_en,
    output logic  rst_act,
    output logic  iso_act,
    output logic  active,
    output logic  irq
);

    localparam int CNT_W = $clog2(RST_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(RST_HOLD - 1);

    logic [CNT_W-1:0] hold_cnt;
    logic [CNT_W-1:0] hold_cnt_nxt;
    logic             rst_nxt;
    logic             iso_nxt;
    logic             active_prev;

    always_comb begin
        rst_nxt      = rst_act;
        hold_cnt_nxt = hold_cnt;
        if (rst_load) begin
            rst_nxt      = 1'b1;
            hold_cnt_nxt = HOLD_LOAD;
        end else if (rst_act) begin
            if (hold_cnt != '0) begin
                hold_cnt_nxt = hold_cnt - 1'b1;
            end else if (!ctrl_nxt.rst) begin
                rst_nxt = 1'b0;
            end
        end
    end

    // fence follows reset up at once and stays one extra cycle after release
    assign iso_nxt = ctrl_nxt.iso | rst_act | rst_nxt;
    assign active  = !iso_act && !rst_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_act     <= 1'b1;
            hold_cnt    <= HOLD_LOAD;
            iso_act     <= 1'b1;
            active_prev <= 1'b0;
            irq         <= 1'b0;
        end else begin
            rst_act     <= rst_nxt;
            hold_cnt    <= hold_cnt_nxt;
            iso_act     <= iso_nxt;
            active_prev <= active;
            irq         <= irq_en && (active ^ active_prev);
        end
    end

endmodule

// File: rtl/region_fence_clamp.sv
module region_fence_clamp #(
    parameter int          W    = 34,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fence,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                dout[i] <= IDLE[i];
            end else begin
                dout[i] <= fence ? IDLE[i] : din[i];
            end
        end
    end

endmodule

// File: rtl/region_fence.sv
module region_fence
    import region_fence_pkg::*;
#(
    parameter int                RST_HOLD  = 16,
    parameter logic [DATA_W-1:0] IDLE_DATA = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cb_sel,
    input  logic              cb_wr,
    input  logic [ADDR_W-1:0] cb_addr,
    input  logic [CB_W-1:0]   cb_wdata,
    output logic [CB_W-1:0]   cb_rdata,
    input  logic [DATA_W-1:0] rgn_data_i,
    input  logic              rgn_valid_i,
    input  logic              rgn_req_i,
    output logic [DATA_W-1:0] st_data_o,
    output logic              st_valid_o,
    output logic              st_req_o,
    output logic              rgn_rst_o,
    output logic              irq_o
);

    localparam rgn_bus_t IDLE_BUS = idle_bus(IDLE_DATA);

    ctrl_t    ctrl_q;
    ctrl_t    ctrl_nxt;
    status_t  status;
    logic     rst_load;
    logic     irq_en;
    logic     rst_act;
    logic     iso_act;
    logic     active;
    rgn_bus_t rgn_bus;
    rgn_bus_t st_bus;

    assign status.iso     = iso_act;
    assign status.rst     = rst_act;
    assign status.active  = active;
    assign status.pending = iso_act && !ctrl_q.iso;

    region_fence_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cb_sel   (cb_sel),
        .cb_wr    (cb_wr),
        .cb_addr  (cb_addr),
        .cb_wdata (cb_wdata),
        .status   (status),
        .ctrl_q   (ctrl_q),
        .ctrl_nxt (ctrl_nxt),
        .rst_load (rst_load),
        .irq_en   (irq_en),
        .cb_rdata (cb_rdata)
    );

    region_fence_seq #(.RST_HOLD(RST_HOLD)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ctrl_nxt (ctrl_nxt),
        .rst_load (rst_load),
        .irq_en   (irq_en),
        .rst_act  (rst_act),
        .iso_act  (iso_act),
        .active   (active),
        .irq      (irq_o)
    );

    assign rgn_bus.data  = rgn_data_i;
    assign rgn_bus.valid = rgn_valid_i;
    assign rgn_bus.req   = rgn_req_i;

    region_fence_clamp #(.W(BUS_W), .IDLE(IDLE_BUS)) u_clamp (
        .clk   (clk),
        .rst   (rst),
        .fence (iso_act),
        .din   (rgn_bus),
        .dout  (st_bus)
    );

    assign st_data_o  = st_bus.data;
    assign st_valid_o = st_bus.valid;
    assign st_req_o   = st_bus.req;
    assign rgn_rst_o  = rst_act;

endmodule

// File: rtl/region_fence_chk.sv
module region_fence_chk
    import region_fence_pkg::*;
#(
    parameter int                RST_HOLD  = 16,
    parameter logic [DATA_W-1:0] IDLE_DATA = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              rgn_rst_o,
    input logic              iso_act,
    input logic              active,
    input logic              irq_en,
    input logic              irq_o,
    input logic [DATA_W-1:0] st_data_o,
    input logic              st_valid_o,
    input logic              st_req_o
);

    localparam int RUN_W = $clog2(RST_HOLD + 2);

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (!rgn_rst_o) begin
            run <= '0;
        end else if (run != RUN_W'(RST_HOLD + 1)) begin
            run <= run + 1'b1;
        end
    end

    // R3: reset never released before the minimum hold
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(rgn_rst_o) |-> (run >= RUN_W'(RST_HOLD)));

    // R4: fence always up while region is in reset
    a_r4_fence_in_reset: assert property (@(posedge clk) disable iff (rst)
        rgn_rst_o |-> iso_act);

    // R5: fence comes down only after reset has been released
    a_r5_drop_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(iso_act) |-> (!rgn_rst_o && !$past(rgn_rst_o)));

    // R6: outputs idle in the cycle after the fence is up
    a_r6_clamp_idle: assert property (@(posedge clk) disable iff (rst)
        $past(iso_act) |-> (st_data_o == IDLE_DATA && !st_valid_o && !st_req_o));

    // R7: an interrupt only follows a change of the active flag
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ($past(active) != $past(active, 2)));

    // R8: no interrupt while the enable was off
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(irq_en));

endmodule

bind region_fence region_fence_chk #(
    .RST_HOLD  (RST_HOLD),
    .IDLE_DATA (IDLE_DATA)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rgn_rst_o  (rgn_rst_o),
    .iso_act    (iso_act),
    .active     (active),
    .irq_en     (irq_en),
    .irq_o      (irq_o),
    .st_data_o  (st_data_o),
    .st_valid_o (st_valid_o),
    .st_req_o   (st_req_o)
);

// File: tb/sim_region_fence.sv
`timescale 1ns/1ps
module sim_region_fence;

    logic        clk = 1'b0;
    logic        rst;
    logic        cb_sel, cb_wr;
    logic [1:0]  cb_addr;
    logic [31:0] cb_wdata, cb_rdata;
    logic [31:0] rgn_data_i;
    logic        rgn_valid_i, rgn_req_i;
    logic [31:0] st_data_o;
    logic        st_valid_o, st_req_o, rgn_rst_o, irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    region_fence u0 (
        .clk(clk), .rst(rst), .cb_sel(cb_sel), .cb_wr(cb_wr), .cb_addr(cb_addr),
        .cb_wdata(cb_wdata), .cb_rdata(cb_rdata), .rgn_data_i(rgn_data_i),
        .rgn_valid_i(rgn_valid_i), .rgn_req_i(rgn_req_i), .st_data_o(st_data_o),
        .st_valid_o(st_valid_o), .st_req_o(st_req_o), .rgn_rst_o(rgn_rst_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cb_sel = 1'b1; cb_wr = 1'b1; cb_addr = a; cb_wdata = d;
        step();
        cb_sel = 1'b0; cb_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cb_addr = a;
        #0.5;
        d = cb_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rgn_data_i = 32'hA5A5_5A5A; rgn_valid_i = 1'b1; rgn_req_i = 1'b1;
        step();
        check("R1 rgn_rst", {31'd0, rgn_rst_o}, 32'd1);
        check("R1 st_data idle", st_data_o, 32'd0);
        check("R1 flags idle", {30'd0, st_valid_o, st_req_o}, 32'd0);
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        rd(2'd0, v); check("R1 ctrl", v, 32'd3);
        rd(2'd2, v); check("R1 irqen", v, 32'd0);
        rd(2'd1, v); check("R1 R2 status", v, 32'h3);
    endtask

    task automatic t_bringup();
        logic [31:0] v;
        bit held = 1'b1;
        wr(2'd2, 32'd1);
        wr(2'd0, 32'd2);   // restart the hold at edge E0
        wr(2'd0, 32'd0);   // request release of both at E1
        rd(2'd1, v); check("R5 pending while reset", v, 32'hB);
        for (int i = 2; i <= 15; i++) begin
            step();
            if (rgn_rst_o !== 1'b1) held = 1'b0;
        end
        check("R3 reset held through hold window", {31'd0, held}, 32'd1);
        step();            // after E16
        check("R3 reset released", {31'd0, rgn_rst_o}, 32'd0);
        rd(2'd1, v); check("R5 fence still up after release", v, 32'h9);
        step();            // after E17
        rd(2'd1, v); check("R5 R7 fence down, active", v, 32'h4);
        check("R7 no irq yet", {31'd0, irq_o}, 32'd0);
        step();            // after E18
        check("R7 irq on enter", {31'd0, irq_o}, 32'd1);
        step();
        check("R7 irq one cycle", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_pass();
        rgn_data_i = 32'h1234_5678; rgn_valid_i = 1'b1; rgn_req_i = 1'b0;
        step();
        check("R6 pass data a", st_data_o, 32'h1234_5678);
        check("R6 pass flags a", {30'd0, st_valid_o, st_req_o}, 32'd2);
        rgn_data_i = 32'hDEAD_BEEF; rgn_valid_i = 1'b0; rgn_req_i = 1'b1;
        check("R6 one-cycle delay", st_data_o, 32'h1234_5678);
        step();
        check("R6 pass data b", st_data_o, 32'hDEAD_BEEF);
        check("R6 pass flags b", {30'd0, st_valid_o, st_req_o}, 32'd1);
    endtask

    task automatic t_fence();
        logic [31:0] v;
        rgn_data_i = 32'hCAFE_0001; rgn_valid_i = 1'b1; rgn_req_i = 1'b1;
        wr(2'd0, 32'd1);   // fence up at E0
        check("R6 data still passes at E0", st_data_o, 32'hCAFE_0001);
        rd(2'd1, v); check("R4 fence applied next edge", v, 32'h1);
        step();            // after E1
        check("R6 clamp data", st_data_o, 32'd0);
        check("R6 clamp flags", {30'd0, st_valid_o, st_req_o}, 32'd0);
        check("R7 irq on leave", {31'd0, irq_o}, 32'd1);
        wr(2'd0, 32'd0);   // drop with no reset: immediate
        rd(2'd1, v); check("R4 fence drops next edge", v, 32'h4);
        step();
        check("R7 irq on re-enter", {31'd0, irq_o}, 32'd1);
        check("R6 pass after drop", st_data_o, 32'hCAFE_0001);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        bit quiet = 1'b1;
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd1);
        for (int i = 0; i < 4; i++) begin
            if (irq_o !== 1'b0) quiet = 1'b0;
            step();
        end
        wr(2'd0, 32'd0);
        for (int i = 0; i < 4; i++) begin
            if (irq_o !== 1'b0) quiet = 1'b0;
            step();
        end
        check("R8 masked irq stays low", {31'd0, quiet}, 32'd1);
        rd(2'd1, v); check("R8 active still tracked", v, 32'h4);
    endtask

    task automatic t_teardown();
        logic [31:0] v;
        bit held = 1'b1;
        wr(2'd0, 32'd3);   // fence and reset at E0
        check("R3 reset asserted next edge", {31'd0, rgn_rst_o}, 32'd1);
        rd(2'd1, v); check("R4 fence with reset", v, 32'h3);
        wr(2'd0, 32'd1);   // early reset release request at E1
        for (int i = 2; i <= 15; i++) begin
            step();
            if (rgn_rst_o !== 1'b1) held = 1'b0;
        end
        check("R3 early release ignored", {31'd0, held}, 32'd1);
        step();
        check("R3 release after hold", {31'd0, rgn_rst_o}, 32'd0);
        step();
        rd(2'd1, v); check("R4 fence kept by request", v, 32'h1);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFF0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd1, v); check("R2 status write ignored", v, 32'h1);
        rd(2'd0, v); check("R2 ctrl unchanged", v, 32'h1);
        rd(2'd2, v); check("R2 irqen unchanged", v, 32'h0);
        rd(2'd3, v); check("R2 unmapped reads zero", v, 32'h0);
    endtask

    initial begin
        rst = 1'b1; cb_sel = 1'b0; cb_wr = 1'b0; cb_addr = '0; cb_wdata = '0;
        rgn_data_i = '0; rgn_valid_i = 1'b0; rgn_req_i = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bringup();
        t_pass();
        t_fence();
        t_mask();
        t_teardown();
        t_regmap();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule